// File: doc/BRIEF.md
# Prioritized Device Interrupt Arbiter

This block gathers service requests from a set of memory-mapped devices (eight by default) and decides whether the processor should be interrupted. Each device has its own status register, reachable over a simple register read/write bus. The register shows the device's live ready flag and holds an interrupt-enable bit that software can write. A device is pending only while both bits are set. Each device is wired to a fixed urgency level from 0 to 7, where 7 is the most urgent.

Among the pending devices, a priority encoder picks the one with the highest level. When two pending devices share a level, the lower device index wins. The winner's level is compared with the processor's current priority. An interrupt is raised only when the winner's level is strictly greater. The interrupt flag, the winning level and the winning device index are registered outputs. The processor samples them at its own instruction boundary, and when the flag is clear it simply continues.

Top module: `irq_arbiter`

## Requirements
- R1: A read of device d's status register (addr_i = d) returns bit 15 = ready_i[d] and bit 14 = the stored enable bit. All other bits read as zero. Reads are combinational.
- R2: A write to device d updates its enable bit from wdata_i[14] at the clock edge. Writes to bit 15 and to every other bit have no effect on what is read back.
- R3: Device d is pending only while ready_i[d] and its enable bit are both 1. A ready device with enable 0, or an enabled device with ready 0, never produces an interrupt.
- R4: Among pending devices, the one with the numerically highest level is chosen. By default the levels for devices 0 to 7 are 4,1,6,3,6,2,0,5.
- R5: When pending devices share the highest level, the lowest device index is chosen.
- R6: irq_o is raised only when the chosen level is strictly greater than cur_pri_i. An equal or lower level gives no interrupt.
- R7: irq_o, irq_lvl_o and irq_idx_o reflect the inputs of the previous clock edge. While irq_o is 0, irq_lvl_o and irq_idx_o are 0.
- R8: After reset, all enable bits are 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Status register write strobe |
| addr_i | input | 3 | Device index of the status register |
| wdata_i | input | 16 | Write data, only bit 14 is used |
| rdata_o | output | 16 | Read data of the addressed status register |
| ready_i | input | 8 | Per-device ready flags |
| cur_pri_i | input | 3 | Priority level of the running program |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_lvl_o | output | 3 | Level of the winning device |
| irq_idx_o | output | 3 | Index of the winning device |

## Verification
An enable write and a change of the processor priority can land on the same clock edge. Then the new enable bit and the new priority act together on the next output update. The bench provokes this by writing a device's enable while lowering cur_pri_i in the same cycle. It expects the interrupt one edge after that write, with the level and index taken from the bench's own model. The bench also provokes a tie at the top level between two enabled devices, and a winner whose level equals the running priority. Each of these cases is judged against the model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned STAT_RDY_BIT = 15;
  localparam int unsigned STAT_EN_BIT  = 14;
  localparam int unsigned STAT_W       = 16;
  localparam int unsigned LVL_W        = 3;
endpackage

// File: rtl/irq_en_regs.sv
module irq_en_regs #(
  parameter int unsigned N_DEV  = 8,
  parameter int unsigned DATA_W = irq_pkg::STAT_W,
  localparam int unsigned ADDR_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_DEV-1:0]  ready_i,
  output logic [N_DEV-1:0]  en_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N_DEV-1:0] en_q;
  logic             addr_ok;

  assign addr_ok = ({1'b0, addr_i} < (ADDR_W+1)'(N_DEV));

  for (genvar g = 0; g < N_DEV; g++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        en_q[g] <= 1'b0;
      else if (wr_en_i && addr_i == ADDR_W'(g))
        en_q[g] <= wdata_i[irq_pkg::STAT_EN_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_ok) begin
      rdata_o[irq_pkg::STAT_RDY_BIT] = ready_i[addr_i];
      rdata_o[irq_pkg::STAT_EN_BIT]  = en_q[addr_i];
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_DEV = 8,
  parameter int unsigned LVL_W = irq_pkg::LVL_W,
  parameter logic [N_DEV*LVL_W-1:0] DEV_LVL = '0,
  localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic [N_DEV-1:0] req_i,
  output logic             found_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [LVL_W-1:0] dev_lvl [N_DEV];

  for (genvar g = 0; g < N_DEV; g++) begin : g_lvl
    assign dev_lvl[g] = DEV_LVL[g*LVL_W +: LVL_W];
  end

  // ascending scan, strict compare: ties keep the lower index
  always_comb begin
    found_o = 1'b0;
    lvl_o   = '0;
    idx_o   = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (req_i[i] && (!found_o || dev_lvl[i] > lvl_o)) begin
        found_o = 1'b1;
        lvl_o   = dev_lvl[i];
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_gate_reg.sv
module irq_gate_reg #(
  parameter int unsigned LVL_W = irq_pkg::LVL_W,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             found_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [LVL_W-1:0] cur_pri_i,
  output logic             irq_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [IDX_W-1:0] idx_o
);
  logic fire;

  assign fire = found_i && (lvl_i > cur_pri_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      lvl_o <= '0;
      idx_o <= '0;
    end else begin
      irq_o <= fire;
      lvl_o <= fire ? lvl_i : '0;
      idx_o <= fire ? idx_i : '0;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N_DEV  = 8,
  parameter int unsigned DATA_W = irq_pkg::STAT_W,
  parameter logic [N_DEV*irq_pkg::LVL_W-1:0] DEV_LVL =
    {3'd5, 3'd0, 3'd2, 3'd6, 3'd3, 3'd6, 3'd1, 3'd4},
  localparam int unsigned LVL_W = irq_pkg::LVL_W,
  localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_DEV-1:0]  ready_i,
  input  logic [LVL_W-1:0]  cur_pri_i,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic [IDX_W-1:0]  irq_idx_o
);
  logic [N_DEV-1:0] en_q;
  logic [N_DEV-1:0] req;
  logic             found;
  logic [LVL_W-1:0] win_lvl;
  logic [IDX_W-1:0] win_idx;

  irq_en_regs #(.N_DEV(N_DEV), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ready_i (ready_i),
    .en_o    (en_q),
    .rdata_o (rdata_o)
  );

  assign req = ready_i & en_q;

  irq_prio_enc #(.N_DEV(N_DEV), .LVL_W(LVL_W), .DEV_LVL(DEV_LVL)) u_enc (
    .req_i   (req),
    .found_o (found),
    .lvl_o   (win_lvl),
    .idx_o   (win_idx)
  );

  irq_gate_reg #(.LVL_W(LVL_W), .IDX_W(IDX_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .found_i   (found),
    .lvl_i     (win_lvl),
    .idx_i     (win_idx),
    .cur_pri_i (cur_pri_i),
    .irq_o     (irq_o),
    .lvl_o     (irq_lvl_o),
    .idx_o     (irq_idx_o)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int unsigned N_DEV = 8,
  parameter int unsigned LVL_W = 3,
  parameter logic [N_DEV*LVL_W-1:0] DEV_LVL = '0,
  localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] addr_i,
  input logic [15:0]      wdata_i,
  input logic [N_DEV-1:0] ready_i,
  input logic [N_DEV-1:0] en_q,
  input logic [LVL_W-1:0] cur_pri_i,
  input logic             irq_o,
  input logic [LVL_W-1:0] irq_lvl_o,
  input logic [IDX_W-1:0] irq_idx_o
);
  logic [N_DEV-1:0] pend_q;
  logic [LVL_W-1:0] pri_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      pri_q  <= '0;
    end else begin
      pend_q <= ready_i & en_q;
      pri_q  <= cur_pri_i;
    end
  end

  AST_IRQ_ABOVE_PRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_lvl_o > pri_q); // R6

  AST_IRQ_FROM_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_q[irq_idx_o]); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_lvl_o == '0 && irq_idx_o == '0)); // R7

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == '0) |=> en_q[0] == $past(wdata_i[14])); // R2

  for (genvar j = 0; j < N_DEV; j++) begin : g_win
    AST_WIN_HIGHEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && pend_q[j]) |-> irq_lvl_o >= DEV_LVL[j*LVL_W +: LVL_W]); // R4
    AST_TIE_LOW_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && pend_q[j] && irq_lvl_o == DEV_LVL[j*LVL_W +: LVL_W])
        |-> irq_idx_o <= IDX_W'(j)); // R5
  end
endmodule

bind irq_arbiter irq_arbiter_chk #(.N_DEV(N_DEV), .LVL_W(LVL_W), .DEV_LVL(DEV_LVL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .ready_i   (ready_i),
  .en_q      (en_q),
  .cur_pri_i (cur_pri_i),
  .irq_o     (irq_o),
  .irq_lvl_o (irq_lvl_o),
  .irq_idx_o (irq_idx_o)
);

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  ready = '0;
  logic [2:0]  pri = '0;
  logic        irq;
  logic [2:0]  irq_lvl;
  logic [2:0]  irq_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] en_m = '0;

  always #4 clk = ~clk;

  irq_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_i(ready), .cur_pri_i(pri),
    .irq_o(irq), .irq_lvl_o(irq_lvl), .irq_idx_o(irq_idx)
  );

  function automatic int lvl_of(int d);
    int t[8] = '{4, 1, 6, 3, 6, 2, 0, 5};
    return t[d];
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // model of outputs one edge after (ready, en_m, pri)
  task automatic chk_out(string req);
    int best = -1, bidx = 0;
    for (int d = 0; d < 8; d++)
      if (ready[d] && en_m[d] && lvl_of(d) > best) begin
        best = lvl_of(d); bidx = d;
      end
    if (best > int'(pri)) begin
      chk({req, " irq"}, int'(irq), 1);
      chk({req, " lvl"}, int'(irq_lvl), best);
      chk({req, " idx"}, int'(irq_idx), bidx);
    end else begin
      chk({req, " irq"}, int'(irq), 0);
      chk({req, " lvl"}, int'(irq_lvl), 0);
      chk({req, " idx"}, int'(irq_idx), 0);
    end
  endtask

  task automatic wr(int d, logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(d); wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
    en_m[d] = v[14];
  endtask

  task automatic rd_chk(string req, int d, int exp);
    addr = 3'(d);
    #1;
    chk(req, int'(rdata), exp);
  endtask

  task automatic apply(logic [7:0] r, logic [2:0] p);
    @(negedge clk);
    ready = r; pri = p;
    @(negedge clk);
  endtask

  task automatic t_reset();
    ready = 8'h01;
    #1;
    chk("R8 irq", int'(irq), 0);
    chk("R8 lvl", int'(irq_lvl), 0);
    chk("R8 idx", int'(irq_idx), 0);
    rd_chk("R8 en cleared / R1 rdy bit", 0, 16'h8000);
  endtask

  task automatic t_regs();
    ready = '0;
    wr(3, 16'hFFFF);
    rd_chk("R2 bit15 write ignored, R1 others zero", 3, 16'h4000);
    ready = 8'h08;
    rd_chk("R1 ready and enable", 3, 16'hC000);
    wr(3, 16'hBFFF);
    rd_chk("R2 enable cleared", 3, 16'h8000);
    ready = '0;
  endtask

  task automatic t_gate();
    apply(8'hFF, 3'd0);
    chk_out("R3 ready without enable");
    wr(1, 16'h4000);
    apply(8'hFD, 3'd0);
    chk_out("R3 enable without ready");
    apply(8'h02, 3'd0);
    chk_out("R3 both set");
  endtask

  task automatic t_prio();
    for (int d = 0; d < 8; d++) wr(d, 16'h4000);
    apply(8'hFF, 3'd0);
    chk_out("R5 tie at level 6 picks dev 2");
    chk("R5 idx", int'(irq_idx), 2);
    apply(8'h81, 3'd0);
    chk_out("R4 dev7 over dev0");
    chk("R4 lvl", int'(irq_lvl), 5);
    apply(8'h38, 3'd0);
    chk_out("R4 dev4 over dev3,5");
  endtask

  task automatic t_strict();
    apply(8'h80, 3'd5);
    chk_out("R6 equal level blocked");
    chk("R6 no irq at equal", int'(irq), 0);
    apply(8'h80, 3'd4);
    chk_out("R6 higher level passes");
    apply(8'h14, 3'd7);
    chk_out("R6 running at 7");
  endtask

  task automatic t_timing();
    apply(8'h00, 3'd0);
    @(negedge clk);
    ready = 8'h04;
    #1;
    chk("R7 no change before edge", int'(irq), 0);
    @(negedge clk);
    chk("R7 one edge later", int'(irq), 1);
    chk("R7 idx", int'(irq_idx), 2);
  endtask

  task automatic t_same_cycle();
    wr(2, 16'h0000);
    apply(8'h04, 3'd6);
    chk_out("R3 dev2 disabled");
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd2; wdata = 16'h4000; pri = 3'd1;
    @(negedge clk);
    wr_en = 1'b0; en_m[2] = 1'b1;
    chk("R7 write+pri same edge, no irq yet", int'(irq), 0);
    @(negedge clk);
    chk_out("R2 R6 write and priority together");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gate();
    t_prio();
    t_strict();
    t_timing();
    t_same_cycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule